// File: doc/BRIEF.md
# Dual-Compare PWM Timer

This block produces a pulse-width modulated waveform from a 16-bit up-counter and two compare values. The counter advances once per timer tick, with one tick every `TICK_DIV` clocks. One compare value sets where the pulse ends, measured from the start of a period. The other compare value sets where the period ends. At the end of each period the counter jumps back to FFFCh rather than to zero. The output pin then takes a programmed "period" level. When the counter reaches the pulse compare value, the pin takes a programmed "pulse" level.

Software sets up the block through a small write port. The port carries the two compare values, a control word and a flag-acknowledge strobe. Each period boundary raises a sticky flag, which stays set until software acknowledges it. New compare values are held in staging registers and take effect only at a period boundary, so no period ever mixes old and new settings. While the block is disabled, the counter is parked at FFFCh and the pin rests at the pulse level.

Top module: `cmp_pwm_timer`

## Requirements
- R1: After reset the output pin is 0 and the flag is 0.
- R2: A write with `wr_en` high stores `wr_data` according to `wr_sel`. Select 0 is the pulse compare and select 1 is the period compare. Select 2 is the control word: bit 0 is the enable, bit 1 is the pulse level and bit 2 is the period level. Select 3 acknowledges the flag, and its data is ignored.
- R3: While enabled, the counter advances by one on each tick, with one tick every `TICK_DIV` clocks. It wraps from FFFFh to 0000h.
- R4: While enabled, a tick that finds the counter equal to the period compare reloads the counter with FFFCh and drives the period level on the pin. A period therefore lasts (P+5) ticks for a period compare P below FFFCh, and (P−FFFCh+1) ticks otherwise.
- R5: While enabled, a tick that finds the counter equal to the pulse compare, with no period match, drives the pulse level on the pin. The period level therefore lasts (C+5) ticks for a pulse compare C below FFFCh, and (C−FFFCh+1) ticks otherwise.
- R6: A period match sets the flag. The flag then holds until a write to select 3, and a set in the same cycle as an acknowledge wins.
- R7: Compare values written while enabled take effect only at the next period match.
- R8: While disabled, the pin follows the pulse level and no period matches occur. The pin changes on the second clock edge after the control write. The counter is parked at FFFCh, and enabling starts it from there with the latest compare values.
- R9: When the pulse compare equals the period compare, the pin stays at the period level.
- R10: When the pulse compare is never reached within a period, the pin stays at the period level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | PWM output pin |
| period_flag | output | 1 | Sticky period-boundary flag |

## Verification
A control write is registered on the first edge and reaches the pin on the second edge, so disabled-level checks sample two cycles after the write. A flag acknowledge takes effect on the first edge and is sampled at the following falling edge. Waveform results cannot be pinned to a single cycle, because the tick phase is free-running. The bench therefore counts falling edges spent at each level, starting from the first period-level edge, and compares those counts with the tick formulas multiplied by `TICK_DIV`. Staged compare values are checked by writing mid-period and confirming that the current high time is unchanged while the next one follows the new value.

// File: rtl/cmp_pwm_pkg.sv
// Shared types for the dual-compare PWM timer.
package cmp_pwm_pkg;
    typedef enum logic [1:0] {
        SEL_PULSE  = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_ACK    = 2'd3
    } wr_sel_e;

    // Control word, bit 2 down to bit 0.
    typedef struct packed {
        logic lvl_period;
        logic lvl_pulse;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/pwm_tick_gen.sv
// Fixed clock divider: pulses tick for one clock every DIV clocks.
// Assumes DIV >= 1; DIV == 1 makes tick permanently high.
module pwm_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            logic [PW-1:0] pre_q;
            // Count 0..DIV-1 and restart.
            always_ff @(posedge clk) begin
                if (!rst_n)                       pre_q <= '0;
                else if (pre_q == PW'(DIV - 1))   pre_q <= '0;
                else                              pre_q <= pre_q + 1'b1;
            end
            assign tick = (pre_q == PW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/pwm_regs.sv
// Write-port decode, control word and staged/active compare values.
// Active values reload from staging while disabled or at a period match.
module pwm_regs
    import cmp_pwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         period_hit,
    output ctrl_t        ctrl_q,
    output logic [W-1:0] act_pulse,
    output logic [W-1:0] act_period,
    output logic         flag_clr
);
    logic [W-1:0] stg_pulse, stg_period;

    // Capture software writes into staging and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_pulse  <= '0;
            stg_period <= '0;
            ctrl_q     <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_PULSE:  stg_pulse  <= wr_data;
                SEL_PERIOD: stg_period <= wr_data;
                SEL_CTRL:   ctrl_q     <= ctrl_t'(wr_data[2:0]);
                default: ;
            endcase
        end
    end

    // Move staged values into use only at safe moments.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_pulse  <= '0;
            act_period <= '0;
        end else if (!ctrl_q.run || period_hit) begin
            act_pulse  <= stg_pulse;
            act_period <= stg_period;
        end
    end

    // Acknowledge strobe for the flag.
    assign flag_clr = wr_en && (wr_sel == SEL_ACK);
endmodule

// File: rtl/pwm_core.sv
// Counter, compare matches, output pin and sticky flag.
// Assumes the compare inputs are stable except at period matches.
module pwm_core
    import cmp_pwm_pkg::*;
#(
    parameter int W = 16,
    parameter logic [W-1:0] RELOAD = 16'hFFFC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  ctrl_t        ctrl_q,
    input  logic [W-1:0] act_pulse,
    input  logic [W-1:0] act_period,
    input  logic         flag_clr,
    output logic [W-1:0] cnt_q,
    output logic         period_hit,
    output logic         pwm_q,
    output logic         flag_q
);
    logic pulse_hit;

    assign period_hit = tick && ctrl_q.run && (cnt_q == act_period);
    assign pulse_hit  = tick && ctrl_q.run && (cnt_q == act_pulse);

    // Counter: parked while idle, reload on period match, else step.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= RELOAD;
        else if (!ctrl_q.run)    cnt_q <= RELOAD;
        else if (period_hit)     cnt_q <= RELOAD;
        else if (tick)           cnt_q <= cnt_q + 1'b1;
    end

    // Output pin: period match has priority over pulse match.
    always_ff @(posedge clk) begin
        if (!rst_n)              pwm_q <= 1'b0;
        else if (!ctrl_q.run)    pwm_q <= ctrl_q.lvl_pulse;
        else if (period_hit)     pwm_q <= ctrl_q.lvl_period;
        else if (pulse_hit)      pwm_q <= ctrl_q.lvl_pulse;
    end

    // Sticky flag: set wins over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)              flag_q <= 1'b0;
        else if (period_hit)     flag_q <= 1'b1;
        else if (flag_clr)       flag_q <= 1'b0;
    end
endmodule

// File: rtl/cmp_pwm_timer.sv
// Top of the dual-compare PWM timer: divider, registers and core.
// Assumes a single clock domain and synchronous active-low reset.
module cmp_pwm_timer
    import cmp_pwm_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int TICK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out,
    output logic             period_flag
);
    localparam logic [CNT_W-1:0] RELOAD_VAL = ~CNT_W'(3);

    logic             tick;
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] act_pulse, act_period, cnt_q;
    logic             flag_clr, period_hit;

    pwm_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    pwm_regs #(.W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .period_hit(period_hit), .ctrl_q(ctrl_q),
        .act_pulse(act_pulse), .act_period(act_period), .flag_clr(flag_clr)
    );

    pwm_core #(.W(CNT_W), .RELOAD(RELOAD_VAL)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_q(ctrl_q),
        .act_pulse(act_pulse), .act_period(act_period), .flag_clr(flag_clr),
        .cnt_q(cnt_q), .period_hit(period_hit), .pwm_q(pwm_out),
        .flag_q(period_flag)
    );
endmodule

// File: rtl/pwm_timer_chk.sv
// Property checker for cmp_pwm_timer, attached by bind.
module pwm_timer_chk #(
    parameter int W = 16,
    parameter logic [W-1:0] RELOAD = 16'hFFFC
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         run,
    input logic         lvl_pulse,
    input logic         lvl_period,
    input logic [W-1:0] cnt,
    input logic [W-1:0] act_pulse,
    input logic [W-1:0] act_period,
    input logic         flag_clr,
    input logic         pwm_out,
    input logic         flag
);
    logic per_m, pul_m;
    assign per_m = tick && run && (cnt == act_period);
    assign pul_m = tick && run && (cnt == act_pulse) && !per_m;

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !per_m) |=> (cnt == W'($past(cnt) + 1'b1)));
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        per_m |=> (cnt == RELOAD));
    p_pin_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
        per_m |=> (pwm_out == $past(lvl_period)));
    p_pin_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pul_m |=> (pwm_out == $past(lvl_pulse)));
    p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        per_m |=> flag);
    p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);
    p_flag_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !per_m) |=> !flag);
    p_staged_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !per_m) |=> ($stable(act_pulse) && $stable(act_period)));
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ((cnt == RELOAD) && (pwm_out == $past(lvl_pulse))));
endmodule

bind cmp_pwm_timer pwm_timer_chk #(.W(CNT_W), .RELOAD(RELOAD_VAL)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctrl_q.run),
    .lvl_pulse(ctrl_q.lvl_pulse), .lvl_period(ctrl_q.lvl_period),
    .cnt(cnt_q), .act_pulse(act_pulse), .act_period(act_period),
    .flag_clr(flag_clr), .pwm_out(pwm_out), .flag(period_flag)
);

// File: tb/sim_cmp_pwm_timer.sv
module sim_cmp_pwm_timer;
    localparam int DIV = 4;
    localparam int NV  = 4;
    // Vectors: pulse compare, period compare, pulse level, period level,
    // expected clocks at period level, expected clocks at pulse level.
    localparam logic [15:0] V_PUL [NV] = '{16'd2, 16'd0, 16'hFFFD, 16'hFFFD};
    localparam logic [15:0] V_PER [NV] = '{16'd10, 16'd3, 16'd5, 16'hFFFE};
    localparam logic        V_L1  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic        V_L2  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0};
    localparam int          V_HI  [NV] = '{7*DIV, 5*DIV, 2*DIV, 2*DIV};
    localparam int          V_LO  [NV] = '{8*DIV, 3*DIV, 8*DIV, 1*DIV};

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic pwm_out, period_flag;
    int n_chk = 0, n_bad = 0, cyc = 0;

    always #2 clk = ~clk;

    cmp_pwm_timer #(.CNT_W(16), .TICK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pwm_out(pwm_out), .period_flag(period_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    // Called at a falling edge, returns at the next falling edge.
    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cfg(input logic [15:0] pul, input logic [15:0] per,
                       input logic l1, input logic l2);
        wr(2'd2, {13'd0, l2, l1, 1'b0});
        wr(2'd0, pul);
        wr(2'd1, per);
        wr(2'd3, 16'd0);
        wr(2'd2, {13'd0, l2, l1, 1'b1});
    endtask

    task automatic measure(input logic l2, output int hi, output int lo);
        while (pwm_out != l2) @(negedge clk);
        hi = 0;
        while (pwm_out == l2) begin hi++; @(negedge clk); end
        lo = 0;
        while (pwm_out != l2) begin lo++; @(negedge clk); end
    endtask

    task automatic hold_check(input logic lvl, input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out != lvl) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    initial begin
        int hi, lo;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pwm_out == 1'b0, "R1 pin", pwm_out, 0);
        check(period_flag == 1'b0, "R1 flag", period_flag, 0);

        // Vector table: R2 encodings, R3 stepping and wrap, R4 and R5 lengths.
        for (int v = 0; v < NV; v++) begin
            cfg(V_PUL[v], V_PER[v], V_L1[v], V_L2[v]);
            measure(V_L2[v], hi, lo);
            check(hi == V_HI[v], $sformatf("R5 R3 row%0d high", v), hi, V_HI[v]);
            check(lo == V_LO[v], $sformatf("R4 R3 row%0d low", v), lo, V_LO[v]);
            check(period_flag == 1'b1, $sformatf("R6 row%0d flag", v), period_flag, 1);
        end

        // R6 and R8: flag sticks while disabled, acknowledge clears it, pin idles.
        wr(2'd2, 16'b010);
        @(negedge clk);
        check(pwm_out == 1'b1, "R8 idle level high", pwm_out, 1);
        repeat (100) @(negedge clk);
        check(period_flag == 1'b1, "R6 sticky", period_flag, 1);
        wr(2'd3, 16'hABCD);
        check(period_flag == 1'b0, "R6 ack", period_flag, 0);
        wr(2'd2, 16'b100);
        @(negedge clk);
        check(pwm_out == 1'b0, "R8 idle level low", pwm_out, 0);
        hold_check(1'b0, 100, "R8 idle hold");
        check(period_flag == 1'b0, "R8 no match idle", period_flag, 0);

        // R9: pulse equals period, pin stays at period level.
        cfg(16'd6, 16'd6, 1'b0, 1'b1);
        while (pwm_out != 1'b1) @(negedge clk);
        hold_check(1'b1, 200, "R9 equal compares");

        // R10: pulse compare outside the period, pin stays at period level.
        cfg(16'h0100, 16'd6, 1'b0, 1'b1);
        while (pwm_out != 1'b1) @(negedge clk);
        hold_check(1'b1, 200, "R10 unreachable pulse");
        check(period_flag == 1'b1, "R6 flag on period", period_flag, 1);

        // R7: staged compare values.
        cfg(16'd2, 16'd10, 1'b0, 1'b1);
        while (pwm_out != 1'b0) @(negedge clk);
        while (pwm_out != 1'b1) @(negedge clk);
        while (pwm_out != 1'b0) @(negedge clk);
        wr(2'd0, 16'd5);
        measure(1'b1, hi, lo);
        check(hi == 10*DIV, "R7 new pulse next period", hi, 10*DIV);
        // Now at the first period-level falling edge.
        hi = 1;
        wr(2'd0, 16'd2);
        while (pwm_out == 1'b1) begin hi++; @(negedge clk); end
        check(hi == 10*DIV, "R7 current period unchanged", hi, 10*DIV);
        measure(1'b1, hi, lo);
        check(hi == 7*DIV, "R7 smaller pulse applied", hi, 7*DIV);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule